// File: doc/BRIEF.md
# Widening Int8 Matrix Multiply-Accumulate Unit

This datapath unit takes two 128-bit source words and a 128-bit accumulator word. It returns the accumulator with a 2x2 matrix product added to it. The first source is read as a 2-row by 8-column matrix of bytes. The second source is read as an 8-row by 2-column matrix of bytes. Each of the four 32-bit accumulator lanes gains the 8-term dot product of one row of the first matrix with one column of the second.

A 2-bit mode input sets the signedness of each source on its own. The unit also checks the three 5-bit register indices that come with the request. Every index must be even. A request with the reserved mode, or with any odd index, is flagged illegal. For such a request the accumulator passes through unchanged.

The interface is a plain valid pulse. The result, the illegal flag and the 4-bit register number (the destination index shifted right by one) appear one clock after the request.

Top module: `mma_unit`

## Requirements
- R1: While reset is active and after it ends, out_valid, out_illegal, acc_out and dst_reg are all zero until the first request is taken.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high, and low after a cycle with in_valid low.
- R3: Mode 2'b00 treats both sources as signed two's-complement bytes.
- R4: Mode 2'b01 treats both sources as unsigned bytes.
- R5: Mode 2'b10 treats the first source as unsigned and the second as signed.
- R6: Mode 2'b11 is reserved. It raises out_illegal and returns acc_out equal to the acc_in of the request.
- R7: If any of dst_idx, src_a_idx or src_b_idx has bit 0 set, out_illegal is raised and acc_out equals the request's acc_in. A legal request has out_illegal low.
- R8: Element [r][k] of the first matrix is byte r*8+k of op_a, meaning bits (r*8+k)*8+7 down to (r*8+k)*8. Element [k][c] of the second matrix is byte c*8+k of op_b. Accumulator lane [r][c] occupies bits (r*2+c)*32+31 down to (r*2+c)*32 of acc_in and acc_out.
- R9: Products and sums wrap modulo 2^32 without saturation.
- R10: dst_reg equals bits 4:1 of the request's dst_idx.
- R11: out_illegal is never high while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Signedness select |
| dst_idx | input | 5 | Destination register index |
| src_a_idx | input | 5 | First source register index |
| src_b_idx | input | 5 | Second source register index |
| op_a | input | 128 | First source, 2x8 bytes |
| op_b | input | 128 | Second source, 8x2 bytes |
| acc_in | input | 128 | Accumulator, four 32-bit lanes |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Request was illegal |
| acc_out | output | 128 | Updated accumulator |
| dst_reg | output | 4 | Register number of the destination |

## Verification
The assertions assume that in_valid, mode, the indices and acc_in are sampled only at the clock edge. They also assume every input is a known value in any cycle where in_valid is high. The bench drives all inputs on the falling edge, so each value is settled before the rising edge that captures it. The bench always drives defined values, including in idle cycles.

The stimulus covers each legal mode with directed extreme bytes and with random words. It sends one-hot patterns to pin down the element layout, and uses saturating operands to force wrap-around. It sends the reserved mode and an odd value in each index in turn. Requests run back to back and with idle gaps between them.

// File: rtl/mma_pkg.sv
package mma_pkg;
  localparam int ELEM_W  = 8;
  localparam int ROWS    = 2;
  localparam int DEPTH   = 8;
  localparam int COLS    = 2;
  localparam int ACC_W   = 32;
  localparam int OP_A_W  = ROWS * DEPTH * ELEM_W;
  localparam int OP_B_W  = DEPTH * COLS * ELEM_W;
  localparam int ACC_V_W = ROWS * COLS * ACC_W;
  localparam int EXT_W   = ELEM_W + 1;
  localparam int PROD_W  = 2 * EXT_W;

  typedef enum logic [1:0] {
    MODE_SS  = 2'b00,
    MODE_UU  = 2'b01,
    MODE_US  = 2'b10,
    MODE_RSV = 2'b11
  } mma_mode_e;

  typedef struct packed {
    logic a_uns;
    logic b_uns;
    logic mode_bad;
    logic idx_bad;
  } mma_ctl_t;

  // Widen one element to a signed value one bit wider.
  function automatic logic signed [EXT_W-1:0] widen(input logic [ELEM_W-1:0] e,
                                                    input logic uns);
    widen = uns ? {1'b0, e} : {e[ELEM_W-1], e};
  endfunction

  // Product of two widened elements, sign-extended to accumulator width.
  function automatic logic signed [ACC_W-1:0] mul_ext(input logic signed [EXT_W-1:0] x,
                                                      input logic signed [EXT_W-1:0] y);
    logic signed [PROD_W-1:0] p;
    p = x * y;
    mul_ext = ACC_W'(p);
  endfunction
endpackage

// File: rtl/mma_decode.sv
module mma_decode
  import mma_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic [IDX_W-1:0] src_b_idx,
  output mma_ctl_t         ctl
);
  mma_mode_e m;
  always_comb begin
    m            = mma_mode_e'(mode);
    ctl.a_uns    = (m == MODE_UU) || (m == MODE_US);
    ctl.b_uns    = (m == MODE_UU);
    ctl.mode_bad = (m == MODE_RSV);
    ctl.idx_bad  = dst_idx[0] | src_a_idx[0] | src_b_idx[0];
  end
endmodule

// File: rtl/mma_lane.sv
module mma_lane
  import mma_pkg::*;
#(
  parameter int ROW = 0,
  parameter int COL = 0
) (
  input  logic [OP_A_W-1:0] op_a,
  input  logic [OP_B_W-1:0] op_b,
  input  logic [ACC_W-1:0]  acc_lane,
  input  logic              a_uns,
  input  logic              b_uns,
  output logic [ACC_W-1:0]  sum_lane
);
  logic signed [ACC_W-1:0] prod [DEPTH];

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_term
      localparam int A_OFF = (ROW * DEPTH + k) * ELEM_W;
      localparam int B_OFF = (COL * DEPTH + k) * ELEM_W;
      assign prod[k] = mul_ext(widen(op_a[A_OFF +: ELEM_W], a_uns),
                               widen(op_b[B_OFF +: ELEM_W], b_uns));
    end
  endgenerate

  always_comb begin
    logic [ACC_W-1:0] s;
    s = acc_lane;
    for (int i = 0; i < DEPTH; i++) s = s + prod[i];
    sum_lane = s;
  end
endmodule

// File: rtl/mma_unit.sv
module mma_unit
  import mma_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int REG_W = IDX_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         mode,
  input  logic [IDX_W-1:0]   dst_idx,
  input  logic [IDX_W-1:0]   src_a_idx,
  input  logic [IDX_W-1:0]   src_b_idx,
  input  logic [OP_A_W-1:0]  op_a,
  input  logic [OP_B_W-1:0]  op_b,
  input  logic [ACC_V_W-1:0] acc_in,
  output logic               out_valid,
  output logic               out_illegal,
  output logic [ACC_V_W-1:0] acc_out,
  output logic [REG_W-1:0]   dst_reg
);
  mma_ctl_t           ctl;
  logic               req_illegal;
  logic [ACC_V_W-1:0] sum_vec;

  mma_decode #(.IDX_W(IDX_W)) u_dec (
    .mode(mode), .dst_idx(dst_idx), .src_a_idx(src_a_idx),
    .src_b_idx(src_b_idx), .ctl(ctl)
  );

  assign req_illegal = ctl.mode_bad | ctl.idx_bad;

  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      for (c = 0; c < COLS; c++) begin : g_col
        localparam int W = (r * COLS + c) * ACC_W;
        mma_lane #(.ROW(r), .COL(c)) u_lane (
          .op_a(op_a), .op_b(op_b),
          .acc_lane(acc_in[W +: ACC_W]),
          .a_uns(ctl.a_uns), .b_uns(ctl.b_uns),
          .sum_lane(sum_vec[W +: ACC_W])
        );
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      acc_out     <= '0;
      dst_reg     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & req_illegal;
      if (in_valid) begin
        acc_out <= req_illegal ? acc_in : sum_vec;
        dst_reg <= dst_idx[IDX_W-1:1];
      end
    end
  end
endmodule

// File: rtl/mma_unit_chk.sv
module mma_unit_chk #(
  parameter int IDX_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         mode,
  input logic [IDX_W-1:0]   dst_idx,
  input logic [IDX_W-1:0]   src_a_idx,
  input logic [IDX_W-1:0]   src_b_idx,
  input logic [127:0]       acc_in,
  input logic               out_valid,
  input logic               out_illegal,
  input logic [127:0]       acc_out,
  input logic [IDX_W-2:0]   dst_reg
);
  logic odd_any;
  assign odd_any = dst_idx[0] | src_a_idx[0] | src_b_idx[0];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r6_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> (out_illegal && acc_out == $past(acc_in)));
  a_r7_odd_index: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && odd_any) |=> (out_illegal && acc_out == $past(acc_in)));
  a_r7_legal_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !odd_any && mode != 2'b11) |=> !out_illegal);
  a_r10_dst_reg: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (dst_reg == $past(dst_idx[IDX_W-1:1])));
  a_r11_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_illegal);
endmodule

bind mma_unit mma_unit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
  .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
  .acc_in(acc_in), .out_valid(out_valid), .out_illegal(out_illegal),
  .acc_out(acc_out), .dst_reg(dst_reg)
);

// File: tb/sim_mma_unit.sv
`timescale 1ns/1ps
module sim_mma_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [4:0]   dst_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic [127:0] op_a = '0, op_b = '0, acc_in = '0;
  logic         out_valid, out_illegal;
  logic [127:0] acc_out;
  logic [3:0]   dst_reg;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  mma_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .dst_idx(dst_idx), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
    .out_valid(out_valid), .out_illegal(out_illegal),
    .acc_out(acc_out), .dst_reg(dst_reg)
  );

  // Behavioural reference: integer dot products, lanes wrapped to 32 bits.
  function automatic logic [127:0] ref_mma(input logic [127:0] a, input logic [127:0] b,
                                           input logic [127:0] acc, input logic [1:0] md);
    logic [127:0] res;
    for (int i = 0; i < 2; i++) begin
      for (int j = 0; j < 2; j++) begin
        longint s;
        s = longint'(acc[(i*2+j)*32 +: 32]);
        for (int k = 0; k < 8; k++) begin
          longint x, y;
          x = (md == 2'b00) ? longint'($signed(a[(i*8+k)*8 +: 8])) : longint'(a[(i*8+k)*8 +: 8]);
          y = (md == 2'b01) ? longint'(b[(j*8+k)*8 +: 8]) : longint'($signed(b[(j*8+k)*8 +: 8]));
          s = s + x * y;
        end
        res[(i*2+j)*32 +: 32] = s[31:0];
      end
    end
    return res;
  endfunction

  logic         exp_v = 0, exp_ill = 0;
  logic [127:0] exp_acc = '0;
  logic [3:0]   exp_reg = '0;
  string        exp_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v <= 0; exp_ill <= 0; exp_acc <= '0; exp_reg <= '0; exp_tag <= "R1";
    end else begin
      exp_v <= in_valid;
      exp_ill <= 0;
      if (in_valid) begin
        logic bad;
        bad = (mode == 2'b11) || dst_idx[0] || src_a_idx[0] || src_b_idx[0];
        exp_ill <= bad;
        exp_acc <= bad ? acc_in : ref_mma(op_a, op_b, acc_in, mode);
        exp_reg <= dst_idx[4:1];
        exp_tag <= cur_tag;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(exp_v ? "R2" : "R2", "out_valid", 128'(out_valid), 128'(exp_v));
      if (exp_v) begin
        check(exp_tag, "out_illegal", 128'(out_illegal), 128'(exp_ill));
        check(exp_tag, "acc_out", acc_out, exp_acc);
        check("R10", "dst_reg", 128'(dst_reg), 128'(exp_reg));
      end else begin
        check("R11", "out_illegal idle", 128'(out_illegal), 128'b0);
        if (exp_tag == "R1") begin
          check("R1", "acc_out reset", acc_out, 128'b0);
          check("R1", "dst_reg reset", 128'(dst_reg), 128'b0);
        end
      end
    end
  end

  task automatic req(input string tag, input logic [1:0] md, input logic [4:0] d,
                     input logic [4:0] n, input logic [4:0] m, input logic [127:0] a,
                     input logic [127:0] b, input logic [127:0] acc);
    @(negedge clk);
    cur_tag = tag; in_valid = 1; mode = md; dst_idx = d; src_a_idx = n; src_b_idx = m;
    op_a = a; op_b = b; acc_in = acc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  function automatic logic [127:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    // R3: signed extremes
    req("R3", 2'b00, 5'd2, 5'd4, 5'd6, {16{8'h80}}, {16{8'h80}}, '0);
    req("R3", 2'b00, 5'd0, 5'd8, 5'd10, {16{8'hFF}}, {16{8'h7F}}, {4{32'd5}});
    // R4: unsigned extremes
    req("R4", 2'b01, 5'd4, 5'd2, 5'd0, {16{8'hFF}}, {16{8'h80}}, '0);
    // R5: mixed
    req("R5", 2'b10, 5'd30, 5'd28, 5'd26, {16{8'hFF}}, {16{8'hFF}}, {4{32'd100}});
    idle(1);
    // R8: one-hot layout probes
    req("R8", 2'b01, 5'd2, 5'd2, 5'd2, 128'h01 << (8*9), 128'h03 << (8*9), '0);
    req("R8", 2'b01, 5'd2, 5'd2, 5'd2, 128'h02 << (8*3), 128'h05 << (8*3), 128'h7 << 64);
    // R9: wrap-around
    req("R9", 2'b01, 5'd6, 5'd6, 5'd6, {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFF0}});
    req("R9", 2'b00, 5'd6, 5'd6, 5'd6, {16{8'h80}}, {16{8'h80}}, {4{32'h7FFF_FFFF}});
    // R6: reserved mode
    req("R6", 2'b11, 5'd2, 5'd4, 5'd6, rnd(), rnd(), rnd());
    idle(2);
    // R7: odd index in each position
    req("R7", 2'b00, 5'd3, 5'd4, 5'd6, rnd(), rnd(), rnd());
    req("R7", 2'b01, 5'd2, 5'd5, 5'd6, rnd(), rnd(), rnd());
    req("R7", 2'b10, 5'd2, 5'd4, 5'd31, rnd(), rnd(), rnd());
    idle(1);
    // random legal traffic across the three modes
    for (int t = 0; t < 60; t++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 2));
      req(md == 2'b00 ? "R3" : (md == 2'b01 ? "R4" : "R5"), md,
          5'($urandom_range(0, 15) * 2), 5'($urandom_range(0, 15) * 2),
          5'($urandom_range(0, 15) * 2), rnd(), rnd(), rnd());
      if (t % 7 == 3) idle(1);
    end
    idle(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule